// File: doc/BRIEF.md
# Multi-Channel Conversion Scan Sequencer

This block decides which analog input channel a successive-approximation converter works on next, and files each result away. Software sets a channel enable mask and writes a start channel number. The write launches a scan. The sequencer hands one channel at a time to the converter engine over a request/done handshake. It begins at the lowest enabled channel at or above the start number and climbs upward, passing over any channel that is not enabled. Channels below the start number are not converted in that scan.

Each result lands in a per-channel register with a data-valid flag and an overwrite flag. Results are kept at full 10-bit width or cut to their upper 8 bits, as a width mode chooses. When the scan runs past its last enabled channel, the sequencer drops its busy flag and raises the interrupt and all-converted flags. It pulls the active-low interrupt line when interrupts are enabled, and gates off the internal conversion oscillator.

The FSM has four states. IDLE waits for a start write (IDLE to PICK). PICK looks for the next enabled channel: it goes to CONV when one is found, or to DONE when none is left. CONV holds the request until done arrives, then goes back to PICK or, after the top channel, to DONE. DONE updates the flags and returns to IDLE.

Top module: `scan_sequencer`

## Requirements
- R1: The first conversion of a scan is on the lowest channel whose mask bit is 1 and whose number is at or above the start channel written by `cfg_we`.
- R2: Later conversions of the scan go to enabled channels in strictly ascending order, each enabled channel at or above the start being converted exactly once, and no channel below the start being converted.
- R3: When the scan completes, `busy` goes to 0 and both `int_flag` and `all_done` go to 1 at the same clock edge.
- R4: `irq_n` is 0 exactly when `int_flag` is 1 and `irq_en` is 1, and is 1 otherwise.
- R5: `osc_run` is 1 during a scan started with `int_osc` = 1, is 0 during a scan started with `int_osc` = 0, and is 0 once the scan completes.
- R6: With `mode_wide` = 1 at the start, a channel stores `conv_result` unchanged. With `mode_wide` = 0, it stores `conv_result[9:2]` in `rd_data[7:0]` with `rd_data[9:8]` = 0.
- R7: A stored result sets that channel's `rd_dv`. If `rd_dv` was already 1, `rd_dov` is set as well and the new data replaces the old. A cycle with `rd_clr` = 1 clears both flags of channel `rd_ch`.
- R8: A `cfg_we` pulse while idle makes `busy` 1 and clears `int_flag` and `all_done` at the next edge.
- R9: A `cfg_we` pulse during a scan is ignored, and the scan continues its original channel order.
- R10: A scan with no enabled channel at or above the start raises no `conv_req` and completes within four cycles of the start write.
- R11: After reset, `busy`, `int_flag`, `all_done`, `osc_run`, `conv_req` and every `rd_dv` and `rd_dov` are 0, and `irq_n` is 1.
- R12: While `conv_req` is 1 and `conv_done` is 0, `conv_req` stays 1 and `conv_ch` holds its value at the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Start channel write strobe; starts a scan when idle |
| cfg_start | input | 3 | Start channel number |
| chan_mask | input | 8 | Channel enable mask, bit n enables channel n |
| mode_wide | input | 1 | 1 = keep 10-bit results, 0 = keep upper 8 bits |
| irq_en | input | 1 | Interrupt line enable |
| int_osc | input | 1 | Internal oscillator in use for this scan |
| conv_req | output | 1 | Conversion request to the converter engine |
| conv_ch | output | 3 | Channel being converted |
| conv_done | input | 1 | Converter engine finished; result valid |
| conv_result | input | 10 | Converter engine result |
| busy | output | 1 | Conversion in progress |
| int_flag | output | 1 | Interrupt status flag |
| all_done | output | 1 | All selected channels converted |
| irq_n | output | 1 | Active-low interrupt line |
| osc_run | output | 1 | Internal conversion oscillator enable |
| rd_ch | input | 3 | Result read channel |
| rd_clr | input | 1 | Clear valid and overwrite flags of `rd_ch` |
| rd_data | output | 10 | Stored result of `rd_ch` |
| rd_dv | output | 1 | Data-valid flag of `rd_ch` |
| rd_dov | output | 1 | Data-overwrite flag of `rd_ch` |

## Verification
A wrong current-channel register shows up at once on `conv_ch`, in the first request after PICK, as a skipped, repeated or descending channel. It also leaves a valid flag set on a channel that should have stayed empty. A wrong state sequence shows as a late or missing fall of `busy`, or as flags that change away from that edge, within one cycle of the last done. Storage faults show up only when a channel is read back, as a wrong data width, a missing valid flag or an overwrite flag that fails to set on a second scan.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PICK = 2'd1,
        ST_CONV = 2'd2,
        ST_DONE = 2'd3
    } scan_state_e;

endpackage

// File: rtl/scan_next_sel.sv
module scan_next_sel #(
    parameter int NCH = 8,
    parameter int CW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [CW-1:0]  from_ch,
    output logic           found,
    output logic [CW-1:0]  sel_ch
);

    logic [NCH-1:0] cand;

    for (genvar i = 0; i < NCH; i++) begin : g_cand
        assign cand[i] = mask[i] && (CW'(i) >= from_ch);
    end

    // lowest candidate wins: scan downward so the last hit is the lowest
    always_comb begin
        found  = 1'b0;
        sel_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found  = 1'b1;
                sel_ch = CW'(i);
            end
        end
    end

endmodule

// File: rtl/scan_result_bank.sv
module scan_result_bank #(
    parameter int NCH   = 8,
    parameter int RES_W = 10,
    parameter int CW    = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_ch,
    input  logic [RES_W-1:0] wr_data,
    input  logic             clr_en,
    input  logic [CW-1:0]    sel_ch,
    output logic [RES_W-1:0] sel_data,
    output logic             sel_dv,
    output logic             sel_dov
);

    logic [RES_W-1:0] data_q [NCH];
    logic [NCH-1:0]   dv_q;
    logic [NCH-1:0]   dov_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                data_q[c] <= '0;
            end
            dv_q  <= '0;
            dov_q <= '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (wr_en && (wr_ch == CW'(c))) begin
                    data_q[c] <= wr_data;
                    dv_q[c]   <= 1'b1;
                    if (clr_en && (sel_ch == CW'(c))) begin
                        dov_q[c] <= 1'b0;
                    end else begin
                        dov_q[c] <= dov_q[c] | dv_q[c];
                    end
                end else if (clr_en && (sel_ch == CW'(c))) begin
                    dv_q[c]  <= 1'b0;
                    dov_q[c] <= 1'b0;
                end
            end
        end
    end

    assign sel_data = data_q[sel_ch];
    assign sel_dv   = dv_q[sel_ch];
    assign sel_dov  = dov_q[sel_ch];

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int RES_W    = 10,
    parameter int NARROW_W = 8,
    parameter int CW       = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CW-1:0]    cfg_start,
    input  logic [NCH-1:0]   chan_mask,
    input  logic             mode_wide,
    input  logic             irq_en,
    input  logic             int_osc,
    output logic             conv_req,
    output logic [CW-1:0]    conv_ch,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             busy,
    output logic             int_flag,
    output logic             all_done,
    output logic             irq_n,
    output logic             osc_run,
    input  logic [CW-1:0]    rd_ch,
    input  logic             rd_clr,
    output logic [RES_W-1:0] rd_data,
    output logic             rd_dv,
    output logic             rd_dov
);

    localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

    scan_state_e      state_q, state_d;
    logic [CW-1:0]    cur_q;
    logic             busy_q, int_q, acc_q, osc_q, wide_q;
    logic             nxt_found;
    logic [CW-1:0]    nxt_ch;
    logic [RES_W-1:0] narrow_res, store_res;
    logic             store_en;

    scan_next_sel #(.NCH(NCH), .CW(CW)) u_next (
        .mask    (chan_mask),
        .from_ch (cur_q),
        .found   (nxt_found),
        .sel_ch  (nxt_ch)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cfg_we) state_d = ST_PICK;
            ST_PICK: state_d = nxt_found ? ST_CONV : ST_DONE;
            ST_CONV: if (conv_done) state_d = (cur_q == LAST_CH) ? ST_DONE : ST_PICK;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            busy_q <= 1'b0;
            int_q  <= 1'b0;
            acc_q  <= 1'b0;
            osc_q  <= 1'b0;
            wide_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cfg_we) begin
                        cur_q  <= cfg_start;
                        busy_q <= 1'b1;
                        int_q  <= 1'b0;
                        acc_q  <= 1'b0;
                        osc_q  <= int_osc;
                        wide_q <= mode_wide;
                    end
                end
                ST_PICK: begin
                    if (nxt_found) cur_q <= nxt_ch;
                end
                ST_CONV: begin
                    if (conv_done && (cur_q != LAST_CH)) cur_q <= cur_q + 1'b1;
                end
                ST_DONE: begin
                    busy_q <= 1'b0;
                    int_q  <= 1'b1;
                    acc_q  <= 1'b1;
                    osc_q  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // result width shaping
    if (NARROW_W < RES_W) begin : g_narrow
        assign narrow_res = {{(RES_W - NARROW_W){1'b0}}, conv_result[RES_W-1 -: NARROW_W]};
    end else begin : g_full
        assign narrow_res = conv_result;
    end

    assign store_res = wide_q ? conv_result : narrow_res;
    assign store_en  = (state_q == ST_CONV) && conv_done;

    scan_result_bank #(.NCH(NCH), .RES_W(RES_W), .CW(CW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (store_en),
        .wr_ch    (cur_q),
        .wr_data  (store_res),
        .clr_en   (rd_clr),
        .sel_ch   (rd_ch),
        .sel_data (rd_data),
        .sel_dv   (rd_dv),
        .sel_dov  (rd_dov)
    );

    assign conv_req = (state_q == ST_CONV);
    assign conv_ch  = cur_q;
    assign busy     = busy_q;
    assign int_flag = int_q;
    assign all_done = acc_q;
    assign osc_run  = osc_q;
    assign irq_n    = ~(int_q & irq_en);

endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk #(
    parameter int NCH = 8,
    parameter int CW  = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_we,
    input logic [NCH-1:0] chan_mask,
    input logic           conv_req,
    input logic [CW-1:0]  conv_ch,
    input logic           conv_done,
    input logic           busy,
    input logic           int_flag,
    input logic           all_done,
    input logic           irq_n,
    input logic           osc_run
);

    logic          have_last;
    logic [CW-1:0] last_ch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_last <= 1'b0;
            last_ch   <= '0;
        end else if (cfg_we && !busy) begin
            have_last <= 1'b0;
        end else if (conv_req && conv_done) begin
            have_last <= 1'b1;
            last_ch   <= conv_ch;
        end
    end

    assert_req_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> chan_mask[conv_ch]);

    assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_done && have_last) |-> (conv_ch > last_ch));

    assert_finish_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (int_flag && all_done));

    assert_irq_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> int_flag);

    assert_osc_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !osc_run);

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !busy) |=> (busy && !int_flag && !all_done));

    assert_req_only_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> busy);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_done) |=> (conv_req && $stable(conv_ch)));

endmodule

bind scan_sequencer scan_sequencer_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .chan_mask (chan_mask),
    .conv_req  (conv_req),
    .conv_ch   (conv_ch),
    .conv_done (conv_done),
    .busy      (busy),
    .int_flag  (int_flag),
    .all_done  (all_done),
    .irq_n     (irq_n),
    .osc_run   (osc_run)
);

// File: tb/tb_scan_sequencer.sv
module tb_scan_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_start = '0;
    logic [7:0] chan_mask = '0;
    logic       mode_wide = 1'b1;
    logic       irq_en = 1'b0;
    logic       int_osc = 1'b0;
    logic       conv_req;
    logic [2:0] conv_ch;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic       busy, int_flag, all_done, irq_n, osc_run;
    logic [2:0] rd_ch = '0;
    logic       rd_clr = 1'b0;
    logic [9:0] rd_data;
    logic       rd_dv, rd_dov;

    int checks = 0;
    int failures = 0;
    int scan_id = 0;
    int log_n = 0;
    int log_ch [64];
    int req_cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    scan_sequencer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_start(cfg_start),
        .chan_mask(chan_mask), .mode_wide(mode_wide), .irq_en(irq_en),
        .int_osc(int_osc), .conv_req(conv_req), .conv_ch(conv_ch),
        .conv_done(conv_done), .conv_result(conv_result), .busy(busy),
        .int_flag(int_flag), .all_done(all_done), .irq_n(irq_n),
        .osc_run(osc_run), .rd_ch(rd_ch), .rd_clr(rd_clr), .rd_data(rd_data),
        .rd_dv(rd_dv), .rd_dov(rd_dov)
    );

    // vector: {mask[7:0], start[2:0], wide, irq_en, int_osc}
    localparam int NVEC = 6;
    localparam logic [13:0] VEC [NVEC] = '{
        {8'hFF, 3'd0, 1'b1, 1'b1, 1'b1},
        {8'hA5, 3'd2, 1'b1, 1'b1, 1'b0},
        {8'h5A, 3'd0, 1'b0, 1'b1, 1'b1},
        {8'h81, 3'd3, 1'b1, 1'b0, 1'b0},
        {8'h0F, 3'd5, 1'b1, 1'b1, 1'b1},
        {8'h80, 3'd7, 1'b0, 1'b0, 1'b1}
    };

    function automatic logic [9:0] res_of(input int ch, input int id);
        return 10'((ch * 97 + id * 29 + 17) % 1024);
    endfunction

    function automatic logic [9:0] shape(input logic [9:0] r, input logic wide);
        return wide ? r : {2'b00, r[9:2]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural converter engine: done three cycles after request
    initial begin
        int wait_cnt;
        int first_ch;
        wait_cnt = 0;
        first_ch = 0;
        forever begin
            @(negedge clk);
            if (conv_req) req_cycles++;
            if (conv_done) begin
                conv_done = 1'b0;
                wait_cnt  = 0;
            end else if (conv_req) begin
                if (wait_cnt == 0) first_ch = int'(conv_ch);
                else chk(int'(conv_ch) == first_ch, "R12", "conv_ch held", int'(conv_ch), first_ch);
                wait_cnt++;
                if (wait_cnt == 3) begin
                    conv_done   = 1'b1;
                    conv_result = res_of(int'(conv_ch), scan_id);
                    if (log_n < 64) log_ch[log_n] = int'(conv_ch);
                    log_n++;
                end
            end
        end
    end

    task automatic clear_all();
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            rd_ch  = 3'(c);
            rd_clr = 1'b1;
        end
        @(negedge clk);
        rd_clr = 1'b0;
    endtask

    task automatic start_scan(input logic [7:0] m, input logic [2:0] st,
                              input logic wd, input logic ie, input logic io);
        @(negedge clk);
        chan_mask = m; cfg_start = st; mode_wide = wd; irq_en = ie; int_osc = io;
        scan_id++;
        log_n = 0;
        req_cycles = 0;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 1;
        while (busy && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk(!busy, "R3", "scan finished", int'(busy), 0);
    endtask

    task automatic check_order(input logic [7:0] m, input int st);
        int n;
        n = 0;
        for (int c = st; c < 8; c++) begin
            if (m[c]) begin
                if (n < log_n)
                    chk(log_ch[n] == c, (n == 0) ? "R1" : "R2", "channel order", log_ch[n], c);
                n++;
            end
        end
        chk(log_n == n, "R2", "conversion count", log_n, n);
    endtask

    initial begin
        int cyc;
        logic [7:0] m;
        logic [2:0] st;
        logic wd, ie, io;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state, R11
        chk(!busy && !int_flag && !all_done, "R11", "flags after reset",
            {busy, int_flag, all_done}, 0);
        chk(irq_n && !osc_run && !conv_req, "R11", "lines after reset",
            {irq_n, osc_run, conv_req}, 4);
        for (int c = 0; c < 8; c++) begin
            rd_ch = 3'(c);
            #1;
            chk(!rd_dv && !rd_dov, "R11", "flags of channel", {rd_dv, rd_dov}, 0);
        end

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            {m, st, wd, ie, io} = VEC[v];
            clear_all();
            start_scan(m, st, wd, ie, io);
            chk(busy && !int_flag && !all_done, "R8", "start clears flags",
                {busy, int_flag, all_done}, 4);
            chk(osc_run == io, "R5", "osc during scan", int'(osc_run), int'(io));
            wait_idle(cyc);
            chk(int_flag && all_done, "R3", "completion flags", {int_flag, all_done}, 3);
            chk(irq_n == !ie, "R4", "irq line", int'(irq_n), int'(!ie));
            chk(!osc_run, "R5", "osc stopped", int'(osc_run), 0);
            check_order(m, int'(st));
            for (int c = 0; c < 8; c++) begin
                bit exp_dv;
                exp_dv = m[c] && (c >= int'(st));
                rd_ch = 3'(c);
                #1;
                chk(rd_dv == exp_dv && !rd_dov, "R7", "valid flags", {rd_dv, rd_dov}, {exp_dv, 1'b0});
                if (exp_dv)
                    chk(rd_data == shape(res_of(c, scan_id), wd), "R6", "stored data",
                        int'(rd_data), int'(shape(res_of(c, scan_id), wd)));
            end
        end

        // R4: irq line follows enable while flag is held
        @(negedge clk);
        irq_en = 1'b1;
        #1;
        chk(!irq_n, "R4", "irq after enable", int'(irq_n), 0);
        irq_en = 1'b0;
        #1;
        chk(irq_n, "R4", "irq after disable", int'(irq_n), 1);

        // R7: overwrite on second scan, then clear
        clear_all();
        start_scan(8'h01, 3'd0, 1'b1, 1'b0, 1'b1);
        wait_idle(cyc);
        start_scan(8'h01, 3'd0, 1'b1, 1'b0, 1'b1);
        wait_idle(cyc);
        rd_ch = 3'd0;
        #1;
        chk(rd_dv && rd_dov, "R7", "overwrite flags", {rd_dv, rd_dov}, 3);
        chk(rd_data == res_of(0, scan_id), "R7", "newest data kept",
            int'(rd_data), int'(res_of(0, scan_id)));
        @(negedge clk);
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
        #1;
        chk(!rd_dv && !rd_dov, "R7", "flags cleared", {rd_dv, rd_dov}, 0);

        // R9: start write during a scan is ignored
        clear_all();
        start_scan(8'hFF, 3'd0, 1'b1, 1'b1, 1'b1);
        repeat (5) @(negedge clk);
        cfg_start = 3'd6;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        wait_idle(cyc);
        chk(log_n == 8, "R9", "conversions despite restart", log_n, 8);
        check_order(8'hFF, 0);

        // R10: empty mask completes quickly without request
        start_scan(8'h00, 3'd0, 1'b1, 1'b1, 1'b1);
        wait_idle(cyc);
        chk(cyc <= 4, "R10", "cycles to finish", cyc, 4);
        chk(req_cycles == 0, "R10", "requests issued", req_cycles, 0);
        chk(int_flag && all_done, "R10", "flags on empty scan", {int_flag, all_done}, 3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule